// File: doc/BRIEF.md
# Cascadable Binary Up/Down Counter with Asynchronous Preset

This block is a small binary counter whose state bits all move together on the rising clock edge. The count steps up or down by one per edge while the active-low enable is asserted. A single direction pin picks the direction, and the count wraps at both ends. An active-low preset pin copies a parallel data word into the count at once, without waiting for a clock edge. The preset also takes priority over counting at any edge where it is still held low.

Two outputs let several counters form a wider word. The terminal flag rises while the count sits at its end value for the selected direction: all ones when counting up, zero when counting down. The active-low ripple output pulses low during the low half of the clock, but only while the terminal flag is high and counting is enabled. The rising edge of that pulse coincides with the clock edge that wraps the stage. It can therefore clock the next stage when all stages share one enable, or drive the next stage's enable when all stages share one clock.

Top module: `cascade_counter`

## Requirements
- R1: All count bits change only on a rising clock edge, apart from reset and preset, and a count step gives the next value in one edge with no intermediate values.
- R2: While `cnt_en_ni` is 1 and `load_ni` is 1, rising clock edges leave `count_o` unchanged.
- R3: With `cnt_en_ni` = 0 and `dir_down_i` = 0, each rising edge adds one to `count_o`, wrapping from all ones to zero.
- R4: With `cnt_en_ni` = 0 and `dir_down_i` = 1, each rising edge subtracts one from `count_o`, wrapping from zero to all ones.
- R5: A 0 on `load_ni` sets `count_o` to `data_i` at once, even in the low half of the clock period.
- R6: While `load_ni` is 0, rising clock edges leave `count_o` equal to `data_i` even with counting enabled.
- R7: `term_o` is 1 exactly when `count_o` is all ones with `dir_down_i` = 0, or zero with `dir_down_i` = 1. It follows a change of direction without waiting for a clock edge.
- R8: `ripple_no` is 0 only while `clk_i` is 0, `term_o` is 1 and `cnt_en_ni` is 0; otherwise it is 1.
- R9: A 0 on `rst_ni` clears `count_o` to zero at once and holds it there.
- R10: Two 4-bit counters, with the second clocked by the first one's `ripple_no` and sharing enable and direction, count through all 256 values of an 8-bit word in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset to zero, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| dir_down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| load_ni | input | 1 | Asynchronous preset, active low |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| term_o | output | 1 | End-of-range flag for the current direction |
| ripple_no | output | 1 | Cascade pulse, low in the clock's low phase at the end of the range |

## Verification
A corrupted count register appears on `count_o` at the next sampling point after the edge that stored it. It also shifts the cycle in which `term_o` and the low ripple pulse appear. In a chained pair, that error shows up as a wrong high nibble one edge later. A wrong direction or enable decode is visible within one edge as a count that is off by two, or off by one, or that fails to change. A preset that waits for the clock is caught in the same half period in which the preset is applied.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cascade_counter_step.sv
module cascade_counter_step
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             run_i,
  input  cnt_dir_e         dir_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // modulo arithmetic gives the wrap in both directions
  always_comb begin
    nxt_o = cur_i;
    if (run_i) begin
      if (dir_i == CNT_DOWN) nxt_o = cur_i - ONE;
      else                   nxt_o = cur_i + ONE;
    end
  end
endmodule

// File: rtl/cascade_counter_link.sv
module cascade_counter_link
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic             run_i,
  input  cnt_dir_e         dir_i,
  output logic             term_o,
  output logic             ripple_no
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic at_end;

  always_comb begin
    if (dir_i == CNT_DOWN) at_end = (cur_i == BOT_VAL);
    else                   at_end = (cur_i == TOP_VAL);
  end

  assign term_o    = at_end;
  // low phase gating: the rising edge lines up with the wrapping clock edge
  assign ripple_no = ~(at_end & run_i & ~clk_i);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_ni,
  input  logic             dir_down_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o,
  output logic             ripple_no
);
  cnt_dir_e         dir;
  logic             run;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  assign dir = cnt_dir_e'(dir_down_i);
  assign run = ~cnt_en_ni;

  cascade_counter_step #(.WIDTH(WIDTH)) u_step (
    .cur_i (cnt_q),
    .run_i (run),
    .dir_i (dir),
    .nxt_o (cnt_d)
  );

  // preset is asynchronous, reset wins over it
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!load_ni) cnt_q <= data_i;
    else               cnt_q <= cnt_d;
  end

  cascade_counter_link #(.WIDTH(WIDTH)) u_link (
    .clk_i     (clk_i),
    .cur_i     (cnt_q),
    .run_i     (run),
    .dir_i     (dir),
    .term_o    (term_o),
    .ripple_no (ripple_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_ni,
  input logic             dir_down_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             term_o,
  input logic             ripple_no
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic armed;
  logic ld_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // marks a preset seen since the last edge
  always_ff @(posedge clk_i or negedge load_ni) begin
    if (!load_ni) ld_evt <= 1'b1;
    else          ld_evt <= 1'b0;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && load_ni && !ld_evt && $past(load_ni) && $past(cnt_en_ni))
      |-> count_o == $past(count_o));

  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && load_ni && !ld_evt && $past(load_ni) && !$past(cnt_en_ni) && !$past(dir_down_i))
      |-> count_o == WIDTH'($past(count_o) + 1'b1));

  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && load_ni && !ld_evt && $past(load_ni) && !$past(cnt_en_ni) && $past(dir_down_i))
      |-> count_o == WIDTH'($past(count_o) - 1'b1));

  a_r6_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> count_o == data_i);

  a_r7_term_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (dir_down_i ? (count_o == '0) : (count_o == ONES)));

  a_r7_end_sets_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_down_i && count_o == ONES) |-> term_o);

  a_r8_ripple_needs_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ripple_no |-> (term_o && !cnt_en_ni));

  a_r8_ripple_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !cnt_en_ni) |-> !ripple_no);
endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_ni  (cnt_en_ni),
  .dir_down_i (dir_down_i),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .count_o    (count_o),
  .term_o     (term_o),
  .ripple_no  (ripple_no)
);

// File: tb/cascade_counter_tb.sv
module cascade_counter_tb;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, en_n, dn, ld_n;
  logic [W-1:0] din;
  wire  [W-1:0] cnt;
  wire          term, rip_n;

  cascade_counter #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(en_n), .dir_down_i(dn),
    .load_ni(ld_n), .data_i(din), .count_o(cnt), .term_o(term), .ripple_no(rip_n)
  );

  // two-stage chain, high stage clocked by the low stage's ripple pulse
  logic       ch_en_n, ch_dn, ch_ld_n;
  logic [7:0] ch_din;
  wire  [3:0] lo_q, hi_q;
  wire        lo_t, hi_t, lo_r, hi_r;

  cascade_counter #(.WIDTH(4)) u_lo (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(ch_en_n), .dir_down_i(ch_dn),
    .load_ni(ch_ld_n), .data_i(ch_din[3:0]), .count_o(lo_q), .term_o(lo_t), .ripple_no(lo_r)
  );
  cascade_counter #(.WIDTH(4)) u_hi (
    .clk_i(lo_r), .rst_ni(rst_n), .cnt_en_ni(ch_en_n), .dir_down_i(ch_dn),
    .load_ni(ch_ld_n), .data_i(ch_din[7:4]), .count_o(hi_q), .term_o(hi_t), .ripple_no(hi_r)
  );

  int total = 0;
  int bad   = 0;
  int m_q   = 0;

  typedef struct {
    logic [W-1:0] q;
    logic         t;
    logic         rl;
    string        req;
  } exp_t;
  exp_t sb[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called with the clock high, just after a rising edge
  task automatic tick(logic e, logic d, string req);
    exp_t it;
    en_n = e;
    dn   = d;
    it.q   = W'(m_q);
    it.t   = d ? (m_q == 0) : (m_q == MAXV);
    it.rl  = it.t && !e;
    it.req = req;
    sb.push_back(it);
    @(posedge clk);
    if (!e) m_q = d ? ((m_q - 1) & MAXV) : ((m_q + 1) & MAXV);
    #1;
  endtask

  task automatic mid_load(int v, string req);
    en_n = 1'b1;
    @(negedge clk);
    #1;
    din  = W'(v);
    ld_n = 1'b0;
    #1;
    chk(req, cnt, v);
    ld_n = 1'b1;
    m_q  = v;
    @(posedge clk);
    #1;
  endtask

  task automatic load_hold(int v);
    en_n = 1'b0;
    dn   = 1'b0;
    din  = W'(v);
    ld_n = 1'b0;
    #1;
    chk("R5", cnt, v);
    @(posedge clk); #2;
    chk("R6", cnt, v);
    @(posedge clk); #2;
    chk("R6", cnt, v);
    en_n = 1'b1;
    #1;
    ld_n = 1'b1;
    m_q  = v;
    @(posedge clk);
    #1;
  endtask

  // monitor: pops one expected item per period and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk({it.req, " count"}, cnt, it.q);
        chk({it.req, " term"}, term, it.t);
        @(negedge clk);
        #1;
        chk({it.req, " ripple"}, rip_n, !it.rl);
      end
    end
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_n = 1'b1; dn = 1'b0; ld_n = 1'b1; din = '0;
    ch_en_n = 1'b1; ch_dn = 1'b0; ch_ld_n = 1'b1; ch_din = '0;
    #2;
    chk("R9", cnt, 0);
    #4;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9", cnt, 0);

    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, "R2");
    tick(1'b1, 1'b1, "R8");            // term high, enable off: no pulse
    tick(1'b0, 1'b1, "R8");            // 0 -> 15 with pulse
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, "R3");
    tick(1'b0, 1'b0, "R1");
    mid_load(12, "R5");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R3");
    tick(1'b0, 1'b1, "R7");            // reversal at 15
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, "R4");
    mid_load(0, "R5");
    tick(1'b0, 1'b0, "R7");            // reversal at 0
    tick(1'b1, 1'b0, "R2");
    load_hold(9);
    tick(1'b1, 1'b0, "R6");
    tick(1'b0, 1'b1, "R4");
    tick(1'b0, 1'b0, "R1");
    tick(1'b1, 1'b0, "R1");
    @(posedge clk); #1;

    // chained 8-bit count, up then down
    ch_din  = 8'h00;
    ch_ld_n = 1'b0;
    #1;
    ch_ld_n = 1'b1;
    chk("R10", {hi_q, lo_q}, 0);
    ch_en_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #2;
      chk("R10 up", {hi_q, lo_q}, (i + 1) & 255);
    end
    #1;
    ch_dn = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #2;
      chk("R10 down", {hi_q, lo_q}, (255 - i) & 255);
    end
    #1;
    ch_en_n = 1'b1;
    @(posedge clk); #2;
    chk("R10 hold", {hi_q, lo_q}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule